// File: doc/BRIEF.md
# Supply Fault Qualifier with Staggered Rail Restart

This block sits between three supply-fault flags and the four regulator rails of a power-management controller. Each flag (input undervoltage, input overvoltage, over-temperature) arrives already digitized and already has its hysteresis. When any flag rises, the block first tells the power-good logic to pull every power-good output low. If the fault is still present after a qualification window, it sends one shutdown request to all rails. A fault that clears before the window ends leaves the rails running.

Once the fault has gone, the rails are allowed back on one at a time, starting with rail 1 and ending with rail 4, at a fixed spacing. When the over-temperature flag took part in the episode, a long guard delay comes before rail 1 is allowed back. All delays count pulses of a timebase tick input, so a test can scale them down.

The per-rail power-good hold timers, soft-start and the threshold comparators are outside this block. A rail is switched on only when its own enable input is high and this block gives it permission.

Top module: `fault_restart_seq`

## Requirements
- R1: During reset and after it is released with no fault flag high, `shutdown_all` and `pg_force_low` are 0, and `rail_go` equals `rail_en`.
- R2: `pg_force_low` is 1 from the first clock edge at which any fault flag is sampled high. It returns to 0 at the first edge at which all three flags are sampled low, whether or not the rails are still down.
- R3: A fault is first sampled at one edge. If it stays present for the next QUAL_TICKS edges that have `tick` high, `shutdown_all` goes to 1 at the last of those edges and `rail_go` becomes 4'b0000.
- R4: A fault that clears before the qualification window completes causes no shutdown: `shutdown_all` stays 0 and `rail_go` keeps following `rail_en`.
- R5: After a shutdown the rails are allowed back in a fixed order: rail 1 (`rail_go[0]`), then rail 2 (bit 1), then rail 3 (bit 2), then rail 4 (bit 3). The set of allowed rails only grows, one rail per step.
- R6: Successive permissions are SLOT_TICKS ticks apart. `shutdown_all` drops at the same edge at which rail 4 receives permission.
- R7: If the over-temperature flag was seen at any point during the episode that led to the shutdown, rail 1 is allowed back only after GUARD_TICKS ticks, counted from the edge at which the cleared flags are first sampled.
- R8: For an episode with only undervoltage or overvoltage, rail 1 is allowed back at the same edge at which the cleared flags are first sampled.
- R9: A new fault during the guard delay or the restart sequence withdraws every permission at once, sets `pg_force_low` again and starts a fresh qualification window. If that fault clears before the window completes, the sequence starts over from rail 1.
- R10: A rail whose `rail_en` is low gets no permission during the sequence, but its slot is still used, so the later rails keep their timing.
- R11: Every delay advances only on clock edges where `tick` is high. While `tick` is low, a held fault never reaches shutdown.
- R12: An over-temperature fault that cleared before qualification completed leaves no trace: a later undervoltage or overvoltage shutdown restarts without the guard delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse; every delay counts these pulses |
| uv_fault | input | 1 | Input undervoltage flag |
| ov_fault | input | 1 | Input overvoltage flag |
| ot_fault | input | 1 | Over-temperature flag |
| rail_en | input | 4 | Per-rail enable, bit 0 is rail 1 |
| pg_force_low | output | 1 | Request to pull every power-good output low |
| shutdown_all | output | 1 | Global rail shutdown request, held until the restart sequence ends |
| rail_go | output | 4 | Per-rail permission to run, bit 0 is rail 1 |

## Verification
A state machine or counter that goes wrong here shows up directly on `rail_go` and `shutdown_all`. Examples are a permission step skipped, a rail released out of order, a guard applied to the wrong kind of fault, or a qualification window off by one tick. The bench predicts these outputs for every cycle of every scenario, so a fault appears as a mismatch within one clock of the edge where the wrong transition occurs. A leftover over-temperature memory is the one fault that stays hidden through a whole episode. It becomes visible only at the start of the next restart, as a missing or extra guard delay.

// File: rtl/fault_restart_seq.sv
module fault_restart_seq #(
  parameter int QUAL_TICKS  = 5000,
  parameter int SLOT_TICKS  = 500,
  parameter int GUARD_TICKS = 2000000,
  parameter int NRAIL       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             uv_fault,
  input  logic             ov_fault,
  input  logic             ot_fault,
  input  logic [NRAIL-1:0] rail_en,
  output logic             pg_force_low,
  output logic             shutdown_all,
  output logic [NRAIL-1:0] rail_go
);

  localparam int MAXT = (GUARD_TICKS > QUAL_TICKS) ?
                        ((GUARD_TICKS > SLOT_TICKS) ? GUARD_TICKS : SLOT_TICKS) :
                        ((QUAL_TICKS > SLOT_TICKS) ? QUAL_TICKS : SLOT_TICKS);
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] QUAL_LAST  = CW'(QUAL_TICKS - 1);
  localparam logic [CW-1:0] SLOT_LAST  = CW'(SLOT_TICKS - 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_TICKS - 1);
  localparam logic [NRAIL-1:0] FIRST = NRAIL'(1);

  typedef enum logic [2:0] {S_RUN, S_QUAL, S_OFF, S_GUARD, S_SEQ} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [NRAIL-1:0] grant;
  logic            down;
  logic            therm;
  logic            pgf;

  wire any_fault = uv_fault | ov_fault | ot_fault;

  assign pg_force_low = pgf;
  assign shutdown_all = down;
  assign rail_go      = down ? (grant & rail_en) : rail_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_RUN;
      cnt   <= '0;
      grant <= '0;
      down  <= 1'b0;
      therm <= 1'b0;
      pgf   <= 1'b0;
    end else begin
      pgf <= any_fault;
      case (st)
        S_RUN: begin
          if (any_fault) begin
            st    <= S_QUAL;
            cnt   <= '0;
            therm <= ot_fault;
          end
        end
        S_QUAL: begin
          if (!any_fault) begin
            cnt <= '0;
            if (!down) begin
              st    <= S_RUN;
              therm <= 1'b0;
            end else if (therm) begin
              st <= S_GUARD;
            end else begin
              st    <= S_SEQ;
              grant <= FIRST;
            end
          end else begin
            therm <= therm | ot_fault;
            if (tick) begin
              if (cnt == QUAL_LAST) begin
                st    <= S_OFF;
                down  <= 1'b1;
                grant <= '0;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        end
        S_OFF: begin
          if (!any_fault) begin
            cnt <= '0;
            if (therm) st <= S_GUARD;
            else begin
              st    <= S_SEQ;
              grant <= FIRST;
            end
          end else begin
            therm <= therm | ot_fault;
          end
        end
        S_GUARD: begin
          if (any_fault) begin
            st    <= S_QUAL;
            cnt   <= '0;
            grant <= '0;
            therm <= therm | ot_fault;
          end else if (tick) begin
            if (cnt == GUARD_LAST) begin
              st    <= S_SEQ;
              grant <= FIRST;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_SEQ: begin
          if (any_fault) begin
            st    <= S_QUAL;
            cnt   <= '0;
            grant <= '0;
            therm <= therm | ot_fault;
          end else if (tick) begin
            if (cnt == SLOT_LAST) begin
              cnt   <= '0;
              grant <= {grant[NRAIL-2:0], 1'b1};
              if (grant[NRAIL-2]) begin
                st    <= S_RUN;
                down  <= 1'b0;
                therm <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  AST_OFF_FORCES_PG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF) |-> pg_force_low); // R2

  AST_SHUTDOWN_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_all) |-> ($past(any_fault) && pg_force_low && rail_go == '0)); // R3

  AST_GRANT_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & (grant + FIRST)) == '0); // R5

  AST_ONE_RAIL_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant & ~$past(grant)) <= 1); // R6

  AST_GRANT_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~$past(grant)) != '0) |-> !$past(any_fault)); // R8

  AST_NO_TICK_NO_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_all) |-> $past(tick)); // R11

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAXT)); // R6

endmodule

// File: tb/sim_fault_restart_seq.sv
module sim_fault_restart_seq;
  localparam int Q = 5;
  localparam int S = 3;
  localparam int G = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic uv = 1'b0, ov = 1'b0, ot = 1'b0;
  logic [3:0] en = 4'b1111;
  logic pgf, sd;
  logic [3:0] go;

  int checks = 0;
  int fails = 0;
  logic [5:0] q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  fault_restart_seq #(.QUAL_TICKS(Q), .SLOT_TICKS(S), .GUARD_TICKS(G), .NRAIL(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .uv_fault(uv), .ov_fault(ov), .ot_fault(ot), .rail_en(en),
    .pg_force_low(pgf), .shutdown_all(sd), .rail_go(go)
  );

  task automatic step(input logic u, input logic o, input logic t, input logic tk,
                      input logic [3:0] e, input logic xsd, input logic [3:0] xgo,
                      input logic xpf, input string tag);
    @(negedge clk);
    uv = u; ov = o; ot = t; tick = tk; en = e;
    q_exp.push_back({xsd, xgo, xpf});
    q_tag.push_back(tag);
  endtask

  task automatic shut(input logic u, input logic o, input logic t, input logic [3:0] e);
    for (int k = 0; k < Q; k++) step(u, o, t, 1'b1, e, 1'b0, e, 1'b1, "R3 qualifying");
    step(u, o, t, 1'b1, e, 1'b1, 4'b0000, 1'b1, "R3 shutdown");
    step(u, o, t, 1'b1, e, 1'b1, 4'b0000, 1'b1, "R3 held down");
  endtask

  task automatic recover(input logic [3:0] e, input int guard);
    for (int k = 0; k < guard; k++) step(1'b0, 1'b0, 1'b0, 1'b1, e, 1'b1, 4'b0000, 1'b0, "R7 guard");
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < S; s++) begin
        if (r == 3) step(1'b0, 1'b0, 1'b0, 1'b1, e, 1'b0, e, 1'b0, "R6 released");
        else step(1'b0, 1'b0, 1'b0, 1'b1, e, 1'b1, 4'((1 << (r + 1)) - 1) & e, 1'b0,
                  (r == 0 && s == 0) ? (guard == 0 ? "R8 first rail" : "R7 first rail") : "R5 R10 slot");
      end
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        logic [5:0] e;
        string tg;
        e = q_exp.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if ({sd, go, pgf} !== e) begin
          fails++;
          $display("FAIL %s: got sd=%b go=%b pgf=%b expected sd=%b go=%b pgf=%b",
                   tg, sd, go, pgf, e[5], e[4:1], e[0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    #2;
    checks++;
    if (sd !== 1'b0 || pgf !== 1'b0 || go !== 4'b1111) begin
      fails++;
      $display("FAIL R1 in reset: got sd=%b go=%b pgf=%b expected 0 1111 0", sd, go, pgf);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 4'b1111, 0, 4'b1111, 0, "R1 after reset");
    step(0, 0, 0, 1, 4'b1010, 0, 4'b1010, 0, "R1 follows enable");

    // R2 R4: short undervoltage, no shutdown
    for (int k = 0; k < Q; k++) step(1, 0, 0, 1, 4'b1111, 0, 4'b1111, 1, "R2 R4 short fault");
    step(0, 0, 0, 1, 4'b1111, 0, 4'b1111, 0, "R4 cleared no shutdown");
    step(0, 0, 0, 1, 4'b1111, 0, 4'b1111, 0, "R4 running");

    // R3 R8 R5 R6: long overvoltage
    shut(0, 1, 0, 4'b1111);
    recover(4'b1111, 0);

    // R7 R10: thermal with rail 3 disabled
    shut(0, 0, 1, 4'b1011);
    recover(4'b1011, G);

    // R9: abort during sequence
    shut(1, 0, 0, 4'b1111);
    step(0, 0, 0, 1, 4'b1111, 1, 4'b0001, 0, "R8 first rail");
    step(0, 0, 0, 1, 4'b1111, 1, 4'b0001, 0, "R6 slot");
    step(0, 0, 0, 1, 4'b1111, 1, 4'b0001, 0, "R6 slot");
    step(0, 0, 0, 1, 4'b1111, 1, 4'b0011, 0, "R5 rail 2");
    step(1, 0, 0, 1, 4'b1111, 1, 4'b0000, 1, "R9 abort");
    recover(4'b1111, 0);

    // R11: no tick, no progress
    for (int k = 0; k < 10; k++) step(0, 1, 0, 0, 4'b1111, 0, 4'b1111, 1, "R11 tick low");
    for (int k = 0; k < Q - 1; k++) step(0, 1, 0, 1, 4'b1111, 0, 4'b1111, 1, "R11 counting");
    step(0, 1, 0, 1, 4'b1111, 1, 4'b0000, 1, "R11 shutdown");
    recover(4'b1111, 0);

    // R12: short thermal, later undervoltage shutdown without guard
    for (int k = 0; k < 3; k++) step(0, 0, 1, 1, 4'b1111, 0, 4'b1111, 1, "R12 short thermal");
    step(0, 0, 0, 1, 4'b1111, 0, 4'b1111, 0, "R12 cleared");
    shut(1, 0, 0, 4'b1111);
    recover(4'b1111, 0);

    step(0, 0, 0, 1, 4'b1111, 0, 4'b1111, 0, "R1 idle");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule